// File: doc/BRIEF.md
# Prioritised Fifteen-Level Interrupt Controller

This block gathers interrupt requests for a processor that takes a 4-bit interrupt level. Fifteen levels, numbered 1 to 15, each have a latched pending bit, an enable bit and a software force bit. Four internal event pulses set pending bits directly: two serial channels, a general-purpose timer and a real-time clock. No external interrupt pins and no edge/level shaping exist. Sources are internal only.

A small register port has a 2-bit select, a write strobe, write data and combinational read data. Software uses it to enable levels, drop pending requests and force any level so that each one can be tested without a hardware source. The controller always presents the highest enabled level that is requested. When the processor takes an interrupt, it returns an acknowledge with the serviced level, and that level's pending bit is removed.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the pending, enable (mask) and force registers read zero and `irq_level` is 0.
- R2: Select 0 reads the pending register, with bit n holding level n. Writes to select 0 are ignored.
- R3: Select 1 is the enable register, readable and writable. A level whose enable bit is 0 is never presented.
- R4: Select 2 is the clear register. It reads as zero, and writing 1 to bit n removes pending level n from the next clock on.
- R5: Select 3 is the force register, readable and writable. A set force bit n requests level n with no hardware event.
- R6: A one-cycle pulse on `ev_uart_a`, `ev_uart_b`, `ev_gpt` or `ev_rtc` sets pending level 4, 5, 12 or 13 respectively on the next clock.
- R7: `irq_level` equals the highest n in 1..15 whose (pending or force) bit and enable bit are both 1. It is 0 when no level qualifies.
- R8: `irq_ack` with `ack_level` = n removes pending level n on the next clock. The force register is unchanged.
- R9: A hardware event in the same cycle as a clear write or an acknowledge for its level leaves that level pending.
- R10: Bit 0 of the pending, enable and force registers always reads 0, and level 0 is never requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 2 | Register select: 0 pending, 1 enable, 2 clear, 3 force |
| bus_we | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 16 | Write data, bit n = level n |
| bus_rdata | output | 16 | Read data of the selected register |
| ev_uart_a | input | 1 | Serial channel A character event pulse (level 4) |
| ev_uart_b | input | 1 | Serial channel B character event pulse (level 5) |
| ev_gpt | input | 1 | General-purpose timer event pulse (level 12) |
| ev_rtc | input | 1 | Real-time clock event pulse (level 13) |
| irq_ack | input | 1 | Processor acknowledge strobe |
| ack_level | input | 4 | Level being acknowledged |
| irq_level | output | 4 | Requested interrupt level, 0 for none |

## Verification
The assertions check on every cycle that the presented level is enabled and requested and that no higher level qualifies. They also check that an acknowledged level drops while force stays put, that hardware events win over clear and acknowledge, that pending ignores bus writes, and that bit 0 never sets. The bench scenarios cover the specific level chosen for each source, the read values of each select, the clear register reading zero, and the way masking, forcing and acknowledging combine into the presented level over a sequence.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NLEV       = 15,
  parameter int LW         = 4,
  parameter int DW         = 16,
  parameter int LVL_UART_A = 4,
  parameter int LVL_UART_B = 5,
  parameter int LVL_GPT    = 12,
  parameter int LVL_RTC    = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_sel,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          ev_uart_a,
  input  logic          ev_uart_b,
  input  logic          ev_gpt,
  input  logic          ev_rtc,
  input  logic          irq_ack,
  input  logic [LW-1:0] ack_level,
  output logic [LW-1:0] irq_level
);

  localparam logic [1:0]    SEL_PEND = 2'd0;
  localparam logic [1:0]    SEL_MASK = 2'd1;
  localparam logic [1:0]    SEL_CLR  = 2'd2;
  localparam logic [1:0]    SEL_FRC  = 2'd3;
  localparam logic [DW-1:0] VALID    = DW'((2 ** (NLEV + 1)) - 2);

  logic [DW-1:0] pend_q, mask_q, frc_q;
  logic [DW-1:0] hw_set, ack_clr, clr_bits, act;
  logic          wr_pend, wr_mask, wr_clr, wr_frc;

  assign wr_pend  = bus_we && (bus_sel == SEL_PEND);
  assign wr_mask  = bus_we && (bus_sel == SEL_MASK);
  assign wr_clr   = bus_we && (bus_sel == SEL_CLR);
  assign wr_frc   = bus_we && (bus_sel == SEL_FRC);
  assign clr_bits = wr_clr ? bus_wdata : '0;

  always_comb begin
    hw_set = '0;
    if (ev_uart_a) hw_set[LVL_UART_A] = 1'b1;
    if (ev_uart_b) hw_set[LVL_UART_B] = 1'b1;
    if (ev_gpt)    hw_set[LVL_GPT]    = 1'b1;
    if (ev_rtc)    hw_set[LVL_RTC]    = 1'b1;
  end

  always_comb begin
    ack_clr = '0;
    if (irq_ack) ack_clr[ack_level] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
      frc_q  <= '0;
    end else begin
      pend_q <= ((pend_q & ~(clr_bits | ack_clr)) | hw_set) & VALID;
      if (wr_mask) mask_q <= bus_wdata & VALID;
      if (wr_frc)  frc_q  <= bus_wdata & VALID;
    end
  end

  assign act = (pend_q | frc_q) & mask_q;

  always_comb begin
    irq_level = '0;
    for (int i = 1; i <= NLEV; i++)
      if (act[i]) irq_level = LW'(i);
  end

  always_comb begin
    case (bus_sel)
      SEL_PEND: bus_rdata = pend_q;
      SEL_MASK: bus_rdata = mask_q;
      SEL_FRC:  bus_rdata = frc_q;
      default:  bus_rdata = '0;
    endcase
  end

  AST_LVL_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != '0) |-> act[irq_level]); // R7
  AST_NONE_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    ((act >> irq_level) >> 1) == '0); // R7
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (act == '0) |-> (irq_level == '0)); // R7
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !hw_set[ack_level]) |=> !pend_q[$past(ack_level)]); // R8
  AST_FORCE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !wr_frc) |=> $stable(frc_q)); // R8
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set != '0) |=> ((pend_q & $past(hw_set)) == $past(hw_set))); // R9
  AST_PEND_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pend && hw_set == '0 && !irq_ack) |=> $stable(pend_q)); // R2
  AST_BIT0_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q[0] && !mask_q[0] && !frc_q[0]); // R10

endmodule

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
  typedef struct {
    string       req;
    bit          is_rd;
    logic [15:0] val;
  } exp_t;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  bus_sel = 0;
  logic        bus_we = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic        ev_uart_a = 0, ev_uart_b = 0, ev_gpt = 0, ev_rtc = 0;
  logic        irq_ack = 0;
  logic [3:0]  ack_level = 0;
  logic [3:0]  irq_level;

  int   total = 0, bad = 0;
  bit   done = 0;
  exp_t q[$];

  always #10 clk = ~clk;

  irq_prio_ctrl u0 (.*);

  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      logic [15:0] got;
      e = q.pop_front();
      got = e.is_rd ? bus_rdata : {12'd0, irq_level};
      total++;
      if (got !== e.val) begin
        bad++;
        $display("FAIL %s %s actual=%h expected=%h", e.req, e.is_rd ? "read" : "level", got, e.val);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
    bus_we = 0; ev_uart_a = 0; ev_uart_b = 0; ev_gpt = 0; ev_rtc = 0; irq_ack = 0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    bus_sel = s; bus_we = 1; bus_wdata = d;
    tick();
  endtask

  task automatic exp_rd(input string r, input logic [1:0] s, input logic [15:0] v);
    exp_t e;
    bus_sel = s;
    e.req = r; e.is_rd = 1; e.val = v;
    q.push_back(e);
    @(negedge clk); #1;
  endtask

  task automatic exp_lvl(input string r, input logic [3:0] v);
    exp_t e;
    e.req = r; e.is_rd = 0; e.val = {12'd0, v};
    q.push_back(e);
    @(negedge clk); #1;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    exp_rd("R1", 2'd0, 16'h0000);
    exp_rd("R1", 2'd1, 16'h0000);
    exp_rd("R1", 2'd3, 16'h0000);
    exp_lvl("R1", 4'd0);

    ev_uart_a = 1; tick();
    exp_rd("R6", 2'd0, 16'h0010);
    exp_lvl("R3", 4'd0);

    wr(2'd1, 16'hFFFF);
    exp_rd("R10", 2'd1, 16'hFFFE);
    exp_lvl("R7", 4'd4);

    ev_uart_b = 1; tick();
    exp_rd("R6", 2'd0, 16'h0030);
    exp_lvl("R7", 4'd5);

    ev_rtc = 1; tick();
    exp_lvl("R6", 4'd13);
    ev_gpt = 1; tick();
    exp_rd("R6", 2'd0, 16'h3030);
    exp_lvl("R7", 4'd13);

    wr(2'd0, 16'h0000);
    exp_rd("R2", 2'd0, 16'h3030);

    wr(2'd2, 16'h2000);
    exp_rd("R4", 2'd0, 16'h1030);
    exp_rd("R4", 2'd2, 16'h0000);
    exp_lvl("R4", 4'd12);

    irq_ack = 1; ack_level = 4'd12; tick();
    exp_rd("R8", 2'd0, 16'h0030);
    exp_lvl("R8", 4'd5);

    wr(2'd3, 16'h8000);
    exp_rd("R5", 2'd3, 16'h8000);
    exp_lvl("R5", 4'd15);
    irq_ack = 1; ack_level = 4'd15; tick();
    exp_rd("R8", 2'd3, 16'h8000);
    exp_lvl("R8", 4'd15);

    wr(2'd3, 16'h0000);
    wr(2'd1, 16'h0010);
    exp_lvl("R3", 4'd4);

    bus_sel = 2'd2; bus_we = 1; bus_wdata = 16'h0010; ev_uart_a = 1; tick();
    exp_rd("R9", 2'd0, 16'h0030);
    exp_lvl("R9", 4'd4);

    irq_ack = 1; ack_level = 4'd5; ev_uart_b = 1; tick();
    exp_rd("R9", 2'd0, 16'h0030);

    wr(2'd3, 16'h0001);
    exp_rd("R10", 2'd3, 16'h0000);
    exp_lvl("R10", 4'd4);

    wr(2'd2, 16'hFFFF);
    exp_rd("R4", 2'd0, 16'h0000);
    exp_lvl("R7", 4'd0);

    wr(2'd3, 16'h0400);
    exp_lvl("R3", 4'd0);
    wr(2'd1, 16'h0400);
    exp_lvl("R5", 4'd10);

    repeat (2) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule